// File: doc/BRIEF.md
# I2S Serial Audio Transmitter (Clock Master)

This block turns parallel stereo audio samples into a single serial data line. It also generates the bit clock and the frame clock itself, from a fixed division of the system clock. Samples enter through a valid/ready handshake that has a one-deep holding buffer. A sample pair is taken out of that buffer once per frame, at the moment its first data bit is due on the line.

Several settings are static configuration inputs: the framing style (standard I2S with a one-bit delay, left-aligned or right-aligned), the sample width (16, 20, 24 or 32 bits) and the frame length (32 or 64 bit clocks). Stereo or mono operation and left/right exchange are static inputs as well. The block captures all of these only while `enable` is low, so changing them while it runs has no effect. The two per-slot mute inputs are different: they are live and are read at every frame start. If the buffer is empty when a frame starts, the previous pair is sent again and `underrun` pulses.

Top module: `i2s_tx_master`

## Requirements
- R1: While `enable` is low, `sck`, `lrck` and `sdo` are all 0. From the first enabled clock, `sck` has a period of 2*HALF_DIV clocks. It stays low for the first HALF_DIV clocks of each bit, and `lrck` and `sdo` change only at the start of a bit, which is never when `sck` rises.
- R2: A frame is 32 bit clocks long (`cfg_frame64`=0) or 64 bit clocks long (`cfg_frame64`=1). The left slot is the first half of the frame. `lrck` is 0 in the left slot when `cfg_fmt`=0 (I2S). For every other code (1 = left-aligned, 2 = right-aligned, 3 = treated as left-aligned), `lrck` is 1 in the left slot.
- R3: In I2S format the MSB of a slot is sent one bit clock after the `lrck` change, and the bits follow MSB first. The LSB of a full-width right slot falls on the first bit of the next frame.
- R4: In left-aligned format the MSB goes out on the same bit clock as the `lrck` change.
- R5: In right-aligned format the LSB goes out on the last bit clock of the slot. The bits before the sample are 0.
- R6: `cfg_width` selects 16/20/24/32 bits with codes 0/1/2/3. The sample occupies the low bits of `s_left`/`s_right`. Slot bits outside the sample are sent as 0.
- R7: Widths above 16 bits combined with a 32-clock frame send only the 16 most significant bits of the sample.
- R8: With `cfg_mono`=1, `s_left` is sent in both slots and `s_right` is ignored.
- R9: With `cfg_swap`=1, the right sample goes out in the left slot and the left sample in the right slot.
- R10: `mute_l` and `mute_r` are read at each frame start. A muted slot sends all zeros for that frame.
- R11: `s_ready` is high exactly when the holding buffer is empty. A transfer happens when `s_valid` and `s_ready` are both high. The buffered pair is consumed at the frame start.
- R12: If no pair is buffered at a frame start, the previous pair is sent again and `underrun` is high for one clock. After `enable` goes low, the previous pair counts as zero.
- R13: Format, width, frame length, mono and swap are captured only while `enable` is low. Changes made while enabled have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run; configuration is captured while low |
| cfg_fmt | input | 2 | 0 I2S, 1 left-aligned, 2 right-aligned |
| cfg_width | input | 2 | 0:16, 1:20, 2:24, 3:32 bits |
| cfg_frame64 | input | 1 | 1: 64 bit clocks per frame, 0: 32 |
| cfg_mono | input | 1 | Send the left input in both slots |
| cfg_swap | input | 1 | Exchange left and right slots |
| mute_l | input | 1 | Zero the left slot |
| mute_r | input | 1 | Zero the right slot |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Holding buffer empty |
| s_left | input | 32 | Left sample, low-aligned |
| s_right | input | 32 | Right sample, low-aligned |
| sck | output | 1 | Bit clock |
| lrck | output | 1 | Frame clock |
| sdo | output | 1 | Serial data |
| underrun | output | 1 | One-clock pulse on a repeated frame |

## Verification
The bench targets the places where each format puts its first bit. If the I2S delay were missing, every slot would shift one bit early. A full-width I2S right slot is a special case: its LSB has to carry into the next frame, and a design that dropped it would send 0 there. Right-aligned framing with 20- or 24-bit samples exposes padding placed at the wrong end. The 24-bit, 32-clock case catches a design that kept the low bits instead of the top 16. Mono, swap and mute are checked per slot, where a swapped polarity or a mute read mid-frame shows up at once. Starving the buffer shows whether the previous pair repeats and whether the underrun flag is exactly one clock long. A configuration change made while running would alter the data stream if the capture were not gated.

// File: rtl/i2s_tx_master.sv
module i2s_tx_master #(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [1:0]  cfg_fmt,
  input  logic [1:0]  cfg_width,
  input  logic        cfg_frame64,
  input  logic        cfg_mono,
  input  logic        cfg_swap,
  input  logic        mute_l,
  input  logic        mute_r,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [31:0] s_left,
  input  logic [31:0] s_right,
  output logic        sck,
  output logic        lrck,
  output logic        sdo,
  output logic        underrun
);
  localparam int PER = 2 * HALF_DIV;
  localparam int TCW = (PER > 2) ? $clog2(PER) : 1;

  logic [1:0]  c_fmt, c_width;
  logic        c_f64, c_mono, c_swap;
  logic        run;
  logic [TCW-1:0] tc;
  logic [5:0]  bit_n;
  logic        hb_valid;
  logic [31:0] hb_l, hb_r, cur_l, cur_r;
  logic        cur_ml, cur_mr;

  logic        is_i2s, is_rj, ev, load;
  logic [5:0]  slot_len, nlast, nn, np, pos, wv, eff, idx;
  logic        sel, illegal, in_rng, muted, sdo_nx, lrck_nx;
  logic [31:0] nl, nr, w_r, w0, w1, word, v;
  logic        nml, nmr;

  assign is_i2s   = (c_fmt == 2'd0);
  assign is_rj    = (c_fmt == 2'd2);
  assign slot_len = c_f64 ? 6'd32 : 6'd16;
  assign nlast    = c_f64 ? 6'd63 : 6'd31;
  assign ev       = enable && (!run || tc == '0);
  assign nn       = !run ? 6'd0 : ((bit_n == nlast) ? 6'd0 : bit_n + 6'd1);
  assign np       = is_i2s ? ((nn == 6'd0) ? nlast : nn - 6'd1) : nn;
  assign load     = ev && (np == 6'd0);

  assign nl  = (load && hb_valid) ? hb_l : cur_l;
  assign nr  = (load && hb_valid) ? hb_r : cur_r;
  assign nml = load ? mute_l : cur_ml;
  assign nmr = load ? mute_r : cur_mr;

  assign w_r = c_mono ? nl : nr;
  assign w0  = c_swap ? w_r : nl;
  assign w1  = c_swap ? nl : w_r;

  assign sel   = c_f64 ? np[5] : np[4];
  assign pos   = c_f64 ? {1'b0, np[4:0]} : {2'b00, np[3:0]};
  assign word  = sel ? w1 : w0;
  assign muted = sel ? nmr : nml;

  always_comb begin
    case (c_width)
      2'd0:    wv = 6'd16;
      2'd1:    wv = 6'd20;
      2'd2:    wv = 6'd24;
      default: wv = 6'd32;
    endcase
  end

  assign illegal = !c_f64 && (c_width != 2'd0);
  assign eff     = illegal ? 6'd16 : wv;
  assign v       = illegal ? (word >> (wv - 6'd16)) : word;
  assign in_rng  = is_rj ? (pos >= slot_len - eff) : (pos < eff);
  assign idx     = is_rj ? (slot_len - 6'd1 - pos) : (eff - 6'd1 - pos);
  assign sdo_nx  = !muted && in_rng && v[idx[4:0]];
  assign lrck_nx = (c_f64 ? nn[5] : nn[4]) ^ !is_i2s;

  assign s_ready = !hb_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_fmt <= '0; c_width <= '0; c_f64 <= 1'b0; c_mono <= 1'b0; c_swap <= 1'b0;
      run <= 1'b0; tc <= '0; bit_n <= '0;
      sck <= 1'b0; lrck <= 1'b0; sdo <= 1'b0; underrun <= 1'b0;
      cur_l <= '0; cur_r <= '0; cur_ml <= 1'b0; cur_mr <= 1'b0;
    end else begin
      underrun <= 1'b0;
      if (!enable) begin
        c_fmt <= cfg_fmt; c_width <= cfg_width; c_f64 <= cfg_frame64;
        c_mono <= cfg_mono; c_swap <= cfg_swap;
        run <= 1'b0; tc <= '0; bit_n <= '0;
        sck <= 1'b0; lrck <= 1'b0; sdo <= 1'b0;
        cur_l <= '0; cur_r <= '0; cur_ml <= 1'b0; cur_mr <= 1'b0;
      end else begin
        run <= 1'b1;
        if (!run)                        tc <= TCW'(1);
        else if (tc == TCW'(PER - 1))    tc <= '0;
        else                             tc <= tc + TCW'(1);
        if (run && tc == TCW'(HALF_DIV)) sck <= 1'b1;
        if (ev) begin
          sck   <= 1'b0;
          bit_n <= nn;
          lrck  <= lrck_nx;
          sdo   <= sdo_nx;
          if (load) begin
            cur_l <= nl; cur_r <= nr; cur_ml <= mute_l; cur_mr <= mute_r;
            underrun <= !hb_valid;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_valid <= 1'b0; hb_l <= '0; hb_r <= '0;
    end else begin
      if (load && hb_valid) hb_valid <= 1'b0;
      if (s_valid && !hb_valid) begin
        hb_valid <= 1'b1; hb_l <= s_left; hb_r <= s_right;
      end
    end
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sck && !lrck && !sdo));
  p_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> ($stable(sdo) && $stable(lrck)));
  p_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);
  p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);
  p_cfg_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> ($stable(c_fmt) && $stable(c_width) && $stable(c_f64)));
endmodule

// File: tb/i2s_tx_master_tb.sv
module i2s_tx_master_tb;
  localparam int HD = 2;
  localparam int PER = 2 * HD;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [1:0] cfg_fmt = '0, cfg_width = '0;
  logic cfg_frame64 = 1'b0, cfg_mono = 1'b0, cfg_swap = 1'b0;
  logic mute_l = 1'b0, mute_r = 1'b0, s_valid = 1'b0;
  logic [31:0] s_left = '0, s_right = '0;
  logic s_ready, sck, lrck, sdo, underrun;

  always #4 clk = ~clk;

  i2s_tx_master #(.HALF_DIV(HD)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_fmt(cfg_fmt), .cfg_width(cfg_width),
    .cfg_frame64(cfg_frame64), .cfg_mono(cfg_mono), .cfg_swap(cfg_swap),
    .mute_l(mute_l), .mute_r(mute_r), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .sck(sck), .lrck(lrck), .sdo(sdo), .underrun(underrun));

  int total = 0, bad = 0;
  bit done = 0, cmp_on = 0, feed_on = 0;
  string tag = "R3";

  // reference model state
  logic [31:0] ql[$], qr[$];
  logic [31:0] pl = '0, pr = '0;
  bit pml = 0, pmr = 0;
  int k_fmt = 0, k_w = 0;
  bit k_f64 = 0, k_mono = 0, k_swap = 0;
  bit m_run = 0; int m_tc = 0, m_n = 0;
  bit e_sck = 0, e_lrck = 0, e_sdo = 0, e_ur = 0, m_acc = 0;
  int kidx = 0;

  function automatic bit bit_for(int np);
    int s, w, e, slot, p, first;
    logic [31:0] lw, rw, word, v;
    bit mu;
    s = k_f64 ? 32 : 16;
    w = (k_w == 0) ? 16 : (k_w == 1) ? 20 : (k_w == 2) ? 24 : 32;
    slot = np / s; p = np % s;
    lw = pl; rw = k_mono ? pl : pr;
    word = (slot == 0) ? (k_swap ? rw : lw) : (k_swap ? lw : rw);
    mu = (slot == 0) ? pml : pmr;
    e = w; v = word;
    if (s == 16 && w > 16) begin e = 16; v = word >> (w - 16); end
    first = (k_fmt == 2) ? s - e : 0;
    if (mu) return 1'b0;
    if (p >= first && p < first + e) return v[e - 1 - (p - first)];
    return 1'b0;
  endfunction

  task automatic emit(int n);
    int s, nf, np;
    s = k_f64 ? 32 : 16; nf = 2 * s;
    np = (k_fmt == 0) ? (n + nf - 1) % nf : n;
    if (np == 0) begin
      if (ql.size() > 0) begin pl = ql.pop_front(); pr = qr.pop_front(); end
      else e_ur = 1;
      pml = mute_l; pmr = mute_r;
    end
    e_lrck = (n >= s) ^ (k_fmt != 0);
    e_sdo = bit_for(np);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ql.delete(); qr.delete(); pl = '0; pr = '0; pml = 0; pmr = 0;
      m_run = 0; m_tc = 0; m_n = 0; e_sck = 0; e_lrck = 0; e_sdo = 0; e_ur = 0; m_acc = 0;
    end else begin
      m_acc = s_valid && (ql.size() == 0);
      e_ur = 0;
      if (!enable) begin
        k_fmt = cfg_fmt; k_w = cfg_width; k_f64 = cfg_frame64; k_mono = cfg_mono; k_swap = cfg_swap;
        m_run = 0; m_tc = 0; m_n = 0; e_sck = 0; e_lrck = 0; e_sdo = 0;
        pl = '0; pr = '0; pml = 0; pmr = 0;
      end else if (!m_run) begin
        m_run = 1; m_tc = 1; m_n = 0; e_sck = 0; emit(0);
      end else begin
        if (m_tc == HD) e_sck = 1;
        if (m_tc == 0) begin
          e_sck = 0;
          m_n = (m_n + 1) % (k_f64 ? 64 : 32);
          emit(m_n);
        end
        m_tc = (m_tc == PER - 1) ? 0 : m_tc + 1;
      end
      if (m_acc) begin ql.push_back(s_left); qr.push_back(s_right); end
    end
  end

  task automatic chk(bit act, bit exp, string req, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  bit p_sck = 0, p_sdo = 0, p_lrck = 0;
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(sck, e_sck, "R1", "sck");
      chk(lrck, e_lrck, "R2", "lrck");
      chk(sdo, e_sdo, tag, "sdo");
      chk(underrun, e_ur, "R12", "underrun");
      chk(s_ready, ql.size() == 0, "R11", "s_ready");
      if (!p_sck && sck) begin
        chk(sdo, p_sdo, "R1", "sdo moved at sck rise");
        chk(lrck, p_lrck, "R1", "lrck moved at sck rise");
      end
    end
    p_sck = sck; p_sdo = sdo; p_lrck = lrck;
    if (m_acc) kidx++;
    s_valid <= feed_on;
    s_left  <= (kidx + 1) * 32'h9E3779B1 ^ 32'h5A0F_3C96;
    s_right <= (kidx + 7) * 32'h7F4A7C15 ^ 32'hC3A5_0F69;
  end

  task automatic scen(int fmt, int w, bit f64, bit mono, bit swp, string t, int frames, bit poke);
    int nbits;
    @(negedge clk);
    enable = 0; cfg_fmt = 2'(fmt); cfg_width = 2'(w); cfg_frame64 = f64;
    cfg_mono = mono; cfg_swap = swp; tag = t;
    repeat (3) @(negedge clk);
    enable = 1;
    nbits = f64 ? 64 : 32;
    repeat (frames * nbits * PER / 2) @(negedge clk);
    if (poke) begin
      cfg_fmt = 2'(fmt + 1); cfg_width = 2'(w + 1); cfg_frame64 = !f64; cfg_swap = !swp;
    end
    repeat (frames * nbits * PER / 2 + 5) @(negedge clk);
    enable = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sck, 1'b0, "R1", "reset sck");
    chk(sdo, 1'b0, "R1", "reset sdo");
    rst_n = 1;
    @(negedge clk);
    chk(s_ready, 1'b1, "R11", "ready after reset");
    cmp_on = 1; feed_on = 1;
    scen(0, 0, 0, 0, 0, "R3", 3, 0);
    scen(0, 2, 1, 0, 0, "R3", 3, 0);
    scen(1, 1, 1, 0, 0, "R4", 3, 0);
    scen(2, 0, 1, 0, 0, "R5", 3, 0);
    scen(2, 1, 1, 0, 0, "R6", 2, 0);
    scen(1, 3, 1, 0, 0, "R6", 2, 0);
    scen(2, 2, 0, 0, 0, "R7", 3, 0);
    scen(0, 1, 0, 0, 0, "R7", 2, 0);
    scen(1, 0, 0, 1, 0, "R8", 3, 0);
    scen(0, 3, 1, 0, 1, "R9", 3, 0);
    fork
      scen(0, 0, 1, 0, 0, "R10", 4, 0);
      begin
        repeat (300) @(negedge clk); mute_l = 1;
        repeat (300) @(negedge clk); mute_r = 1; mute_l = 0;
        repeat (300) @(negedge clk); mute_r = 0;
      end
    join
    scen(1, 2, 1, 0, 0, "R13", 2, 1);
    fork
      scen(2, 3, 1, 0, 1, "R12", 5, 0);
      begin repeat (400) @(negedge clk); feed_on = 0; end
    join
    feed_on = 1;
    scen(0, 0, 1, 1, 1, "R8", 2, 0);
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule